// File: doc/BRIEF.md
# Received Frame Record Packer

This block sits between a receive path and a byte-wide serial link to a host. It takes one received Ethernet frame as a byte stream. The stream carries start and end markers, and the end-marked byte also carries the frame length and the filter verdict. The block holds the frame in an internal buffer until the verdict is known. It then emits a record of fixed size over a valid/ready byte stream. The host can always read a full record and find the true frame length near its end.

Each record is 1600 bytes long and is laid out as follows:

- The frame bytes start at offset zero.
- Zero fill follows the frame bytes up to offset 1595.
- A two-byte big-endian length sits at offsets 1596 and 1597.
- A carriage-return and line-feed pair closes the record.

A frame that the filter rejects leaves no trace on the output. While a record is being sent, the frame input is held off.

Top module: `rx_record_packer`

## Requirements
- R1: Every accepted frame produces exactly 1600 output transfers, after which out_valid stays low until a new frame is accepted.
- R2: Record byte k equals frame byte k for every k below the number of stored frame bytes. Every record byte from there up to offset 1595 is 0x00.
- R3: Record offset 1596 carries bits 15..8 of the (clamped) frame length, and offset 1597 carries bits 7..0.
- R4: Record offset 1598 is 0x0D and offset 1599 is 0x0A.
- R5: The verdict is sampled with the end-marked byte. When in_accept is 0 there, the frame produces no output, and in_ready is high in the following cycle.
- R6: in_ready is low from the cycle after an accepted end-marked byte is taken until after the last record byte (offset 1599) has been transferred. No input byte is taken while a record is being sent.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged in the next cycle.
- R8: Frame bytes beyond the first 1596 are discarded. A length value above 1596 is reported in the record as 1596.
- R9: A byte taken with in_sof high becomes record offset 0 of a new frame. Bytes taken with in_valid high but outside a frame (before any start marker) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_len | input | 16 | Frame length, sampled with the end-marked byte |
| in_accept | input | 1 | Filter verdict, sampled with the end-marked byte (1 = forward) |
| in_ready | output | 1 | Block can take a frame byte |
| out_valid | output | 1 | Record byte present |
| out_data | output | 8 | Record byte |
| out_ready | input | 1 | Downstream takes the record byte |

## Verification
The embedded properties check the following on every cycle:

- The output byte and out_valid stay held while downstream stalls.
- A rejected frame never raises out_valid.
- The stored byte count and the reported length never exceed 1596.
- The input reopens right after the line-feed transfer.
- A start marker restarts the byte count.

Only the bench scenarios can show the record content itself. This covers the payload order, the zero fill, the big-endian length and the trailer. They also show that truncation happens at 1596 bytes and that stray bytes before a start marker are discarded.

// File: rtl/rxrec_pkg.sv
package rxrec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_SEND = 2'd2
    } rec_state_e;

    localparam int LEN_W  = 16;
    localparam int TRL_W  = 4;   // length (2) + CR/LF (2)
    localparam logic [7:0] CR_BYTE = 8'h0D;
    localparam logic [7:0] LF_BYTE = 8'h0A;
endpackage

// File: rtl/rec_buffer.sv
module rec_buffer #(
    parameter int DEPTH = 1596,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < AW'(DEPTH))) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        if (rd_addr < AW'(DEPTH)) begin
            rd_data = mem_q[rd_addr];
        end else begin
            rd_data = 8'h00;
        end
    end
endmodule

// File: rtl/rec_ctrl.sv
module rec_ctrl
    import rxrec_pkg::*;
#(
    parameter int REC_BYTES = 1600,
    parameter int IDX_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [LEN_W-1:0] in_len,
    input  logic             in_accept,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             sending,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] cnt,
    output logic [LEN_W-1:0] len
);
    localparam int PAYLOAD = REC_BYTES - TRL_W;
    localparam logic [IDX_W-1:0] PAY_IDX  = IDX_W'(PAYLOAD);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);
    localparam logic [LEN_W-1:0] PAY_LEN  = LEN_W'(PAYLOAD);

    typedef struct packed {
        rec_state_e       st;
        logic [IDX_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] len;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  take;
    logic  in_frame;

    always_comb begin
        r_d      = r_q;
        wr_en    = 1'b0;
        wr_addr  = r_q.cnt;
        in_ready = (r_q.st != ST_SEND);
        take     = in_valid && in_ready;
        in_frame = in_sof || (r_q.st == ST_FILL);

        if (r_q.st == ST_SEND) begin
            if (out_ready) begin
                if (r_q.idx == LAST_IDX) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
        end else if (take) begin
            if (in_sof) begin
                wr_en   = 1'b1;
                wr_addr = '0;
                r_d.cnt = IDX_W'(1);
                r_d.st  = ST_FILL;
            end else if (r_q.st == ST_FILL && r_q.cnt < PAY_IDX) begin
                wr_en   = 1'b1;
                r_d.cnt = r_q.cnt + 1'b1;
            end
            if (in_eof && in_frame) begin
                if (in_accept) begin
                    r_d.st  = ST_SEND;
                    r_d.idx = '0;
                    r_d.len = (in_len > PAY_LEN) ? PAY_LEN : in_len;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.cnt <= '0;
            r_q.idx <= '0;
            r_q.len <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sending = (r_q.st == ST_SEND);
    assign idx     = r_q.idx;
    assign cnt     = r_q.cnt;
    assign len     = r_q.len;

    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eof && in_frame && !in_accept) |=> (!sending && in_ready)); // R5
    AST_REOPEN_AFTER_LF: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && out_ready && idx == LAST_IDX) |=> (in_ready && !sending)); // R6
    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= PAY_IDX); // R8
    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        sending |-> (len <= PAY_LEN)); // R8
    AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sof) |=> (cnt == IDX_W'(1))); // R9
endmodule

// File: rtl/rec_mux.sv
module rec_mux
    import rxrec_pkg::*;
#(
    parameter int REC_BYTES = 1600,
    parameter int IDX_W     = 11
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] cnt,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       rd_data,
    output logic [7:0]       byte_out
);
    localparam int PAYLOAD = REC_BYTES - TRL_W;
    localparam logic [IDX_W-1:0] OFF_LEN_HI = IDX_W'(PAYLOAD);
    localparam logic [IDX_W-1:0] OFF_LEN_LO = IDX_W'(PAYLOAD + 1);
    localparam logic [IDX_W-1:0] OFF_CR     = IDX_W'(PAYLOAD + 2);

    always_comb begin
        if (idx < cnt) begin
            byte_out = rd_data;
        end else if (idx < OFF_LEN_HI) begin
            byte_out = 8'h00;
        end else if (idx == OFF_LEN_HI) begin
            byte_out = len[15:8];
        end else if (idx == OFF_LEN_LO) begin
            byte_out = len[7:0];
        end else if (idx == OFF_CR) begin
            byte_out = CR_BYTE;
        end else begin
            byte_out = LF_BYTE;
        end
    end
endmodule

// File: rtl/rx_record_packer.sv
module rx_record_packer
    import rxrec_pkg::*;
#(
    parameter int REC_BYTES = 1600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [LEN_W-1:0] in_len,
    input  logic             in_accept,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready
);
    localparam int PAYLOAD = REC_BYTES - TRL_W;
    localparam int IDX_W   = $clog2(REC_BYTES);

    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] cnt;
    logic [LEN_W-1:0] len;
    logic [7:0]       rd_data;

    rec_ctrl #(.REC_BYTES(REC_BYTES), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_len(in_len), .in_accept(in_accept), .out_ready(out_ready),
        .in_ready(in_ready), .sending(out_valid),
        .wr_en(wr_en), .wr_addr(wr_addr),
        .idx(idx), .cnt(cnt), .len(len)
    );

    rec_buffer #(.DEPTH(PAYLOAD), .AW(IDX_W)) u_buf (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
        .rd_addr(idx), .rd_data(rd_data)
    );

    rec_mux #(.REC_BYTES(REC_BYTES), .IDX_W(IDX_W)) u_mux (
        .idx(idx), .cnt(cnt), .len(len), .rd_data(rd_data), .byte_out(out_data)
    );

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
    AST_NO_TAKE_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R6
endmodule

// File: tb/tb_rx_record_packer.sv
`timescale 1ns/1ps
module tb_rx_record_packer;
    localparam int REC = 1600;
    localparam int PAY = REC - 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [15:0] in_len = '0;
    logic        in_accept = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;

    rx_record_packer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_len(in_len), .in_accept(in_accept),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    logic [7:0] fb  [0:2047];
    logic [7:0] rec [0:REC-1];
    int rx_cnt = 0;
    bit rand_ready = 1'b0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    int stall_seen = 0;
    int stall_bad = 0;
    int busy_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_byte(input int i, input int n, input int lenf);
        int st = (n > PAY) ? PAY : n;
        int lc = (lenf > PAY) ? PAY : lenf;
        if (i < st) return int'(fb[i]);
        if (i < PAY) return 0;
        if (i == PAY) return (lc >> 8) & 255;
        if (i == PAY + 1) return lc & 255;
        if (i == PAY + 2) return 13;
        return 10;
    endfunction

    // output side: ready pattern, capture and per-cycle observations
    always @(negedge clk) begin
        if (rst_n) begin
            out_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
            if (prev_stall) begin
                stall_seen++;
                if (!out_valid || out_data != prev_data) stall_bad++;
            end
            if (out_valid && in_ready) busy_bad++;
            if (out_valid && out_ready) begin
                if (rx_cnt < REC) rec[rx_cnt] = out_data;
                rx_cnt++;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    initial begin
        #(4 * 190000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic drive_frame(input int n, input int lenf, input bit acc, input int stray);
        for (int s = 0; s < stray; s++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'hA5;
            @(posedge clk);
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (($urandom % 8) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1; in_data = fb[i];
            in_sof = (i == 0); in_eof = (i == n - 1);
            in_len = 16'(lenf); in_accept = acc;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic run_frame(input int n, input int lenf, input bit acc,
                             input int stray, input string tag);
        int bad_pay;
        int first_bad;
        for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
        rx_cnt = 0;
        drive_frame(n, lenf, acc, stray);
        // first negedge after the end-marked byte edge
        chk(in_ready == !acc, acc ? "R6" : "R5", {tag, " in_ready after end"},
            int'(in_ready), int'(!acc));
        if (!acc) begin
            for (int c = 0; c < 40; c++) @(negedge clk);
            chk(rx_cnt == 0, "R5", {tag, " dropped frame output"}, rx_cnt, 0);
            chk(in_ready == 1'b1, "R5", {tag, " ready after drop"}, int'(in_ready), 1);
            return;
        end
        for (int c = 0; c < 20000 && rx_cnt < REC; c++) @(negedge clk);
        for (int c = 0; c < 3; c++) @(negedge clk);
        chk(rx_cnt == REC, "R1", {tag, " record length"}, rx_cnt, REC);
        chk(!out_valid && in_ready, "R6", {tag, " idle after record"},
            int'(out_valid), 0);
        bad_pay = 0; first_bad = -1;
        for (int i = 0; i < PAY; i++) begin
            if (int'(rec[i]) != exp_byte(i, n, lenf)) begin
                bad_pay++;
                if (first_bad < 0) first_bad = i;
            end
        end
        chk(bad_pay == 0, (n > PAY) ? "R8" : ((stray > 0) ? "R9" : "R2"),
            {tag, " payload/zero mismatches"}, bad_pay, 0);
        chk(int'({rec[PAY], rec[PAY+1]}) == (lenf > PAY ? PAY : lenf),
            (lenf > PAY) ? "R8" : "R3", {tag, " length field"},
            int'({rec[PAY], rec[PAY+1]}), (lenf > PAY ? PAY : lenf));
        chk(rec[PAY+2] == 8'h0D && rec[PAY+3] == 8'h0A, "R4", {tag, " trailer"},
            int'({rec[PAY+2], rec[PAY+3]}), 16'h0D0A);
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R6", "post-reset idle",
            int'(in_ready), 1);

        run_frame(64, 64, 1'b1, 3, "stray+64");          // R9, R2
        run_frame(1, 1, 1'b1, 0, "single byte");         // R2
        run_frame(PAY, PAY, 1'b1, 0, "exact fit");       // R2 R3
        rand_ready = 1'b1;
        run_frame(1700, 1700, 1'b1, 0, "oversize");      // R8
        run_frame(200, 200, 1'b0, 0, "drop");            // R5
        run_frame(300, 300, 1'b1, 0, "after drop");      // R2
        for (int k = 0; k < 8; k++) begin
            int n = 1 + int'($urandom % 1800);
            bit acc = (($urandom % 4) != 0);
            run_frame(n, n, acc, int'($urandom % 3), $sformatf("random%0d", k));
        end
        chk(stall_seen > 0 && stall_bad == 0, "R7", "held byte under stall",
            stall_bad, 0);
        chk(busy_bad == 0, "R6", "input open while sending", busy_bad, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule